// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple host request port and an asynchronous 256K x 8 DRAM. The DRAM has active-low strobes and a 9-pin address bus that carries the row and the column at different times. Each host request carries an 18-bit address and a read/write flag. The controller opens the requested row, strobes the column, and then leaves the row open. A later request to the same row costs only a new column strobe. A request to another row first closes the open row for a programmable recovery time.

All DRAM timing is counted in controller clock cycles, from configuration inputs:

- the row recovery (precharge) time,
- the row-to-column delay,
- the write strobe width,
- the read access time.

A configuration bit picks early or late output-enable timing for reads. A programmable idle count closes an open row when no request arrives within that count.

Top module: `page_dram_ctrl`

## Requirements
- R1: While rst_n is low and straight after its release, dram_ras_n, dram_cas_n, dram_we_n and dram_oe_n are 1, req_ready is 1, rd_valid is 0, and dram_dq is not driven.
- R2: The row is req_addr[17:9] and the column is req_addr[8:0], both carried on dram_addr with the row first. dram_addr is unchanged across the cycle in which dram_ras_n falls and across the cycle in which dram_cas_n falls. dram_cas_n is low only while dram_ras_n is low.
- R3: A request to the row that is currently open produces no new fall of dram_ras_n. A hit read raises rd_valid 1+A clock edges after the accepting edge.
- R4: A request that misses the open row raises dram_ras_n for P cycles and then applies the new row. P is cfg_precharge, and a value of 0 counts as 1. A miss read raises rd_valid P+1+D+A edges after acceptance, where D is cfg_ras_cas and a value of 0 counts as 1.
- R5: A read issued when no row is open raises rd_valid 2+D+A edges after acceptance.
- R6: When cfg_late_oe=0, dram_oe_n is already low in the cycle dram_cas_n falls, and a read keeps dram_cas_n low for A=cfg_access cycles. When cfg_late_oe=1, dram_oe_n is still high in that cycle and goes low in the next one, and A=cfg_access+1.
- R7: Read data is returned on rd_data with rd_valid high for exactly one cycle. It equals the byte last written to that address, or 00 if the address was never written.
- R8: For a write, dram_we_n is low and dram_dq carries the write data already in the cycle before dram_cas_n falls. dram_cas_n then stays low for cfg_cas_width cycles. dram_we_n and dram_oe_n are never low together.
- R9: After cfg_idle cycles in the open state with no request, dram_ras_n goes high. It is still low one cycle earlier. The next access then takes the no-row-open latency.
- R10: req_ready is high only when the controller is idle or holds an open row with no access in flight. It drops in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_precharge | input | 8 | Row recovery cycles with RAS high (0 counts as 1) |
| cfg_ras_cas | input | 8 | Cycles from RAS fall to column setup (0 counts as 1) |
| cfg_cas_width | input | 8 | CAS low cycles for a write (0 counts as 1) |
| cfg_access | input | 8 | Read access cycles counted from output enable and CAS |
| cfg_idle | input | 8 | Open-row idle cycles before the row is closed |
| cfg_late_oe | input | 1 | 1: output enable after CAS; 0: output enable before CAS |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Byte address, row in the upper 9 bits |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on a clock edge where req_valid and req_ready are both high |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| rd_data | output | 8 | Read data |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | inout | 8 | Bidirectional data bus |

## Verification
The assertions check the following strobe-ordering rules on every cycle:

- CAS is low only inside RAS.
- The address is stable at each strobe fall.
- Write enable and output enable never overlap.
- Write enable is set up before CAS.
- Output enable takes its early or late position at CAS fall.
- rd_valid is a single-cycle pulse.
- The host is never offered ready while CAS is low.

Only the bench's scenarios can show the following:

- the exact read latencies for hit, miss and idle starts,
- the counted CAS widths,
- the absence of a RAS fall on page hits,
- data integrity through a behavioural memory,
- the treatment of a zero precharge count,
- the exact cycle in which the idle timeout closes the row.

// File: rtl/dram_fpm_pkg.sv
// Package: shared state type for the page mode DRAM controller.
// Assumes nothing beyond a 4-bit state encoding.
package dram_fpm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,   // no row open, RAS high
        ST_PRE,    // RAS high, row address driven, recovery count
        ST_RCD,    // RAS low, row address held, row-to-column count
        ST_COL,    // column address setup, CAS high
        ST_CAS,    // CAS low for width or access count
        ST_CASHI,  // CAS high recovery, row stays open
        ST_OPEN,   // row open, waiting for a request or idle timeout
        ST_CLOSE   // RAS high recovery after idle close
    } fpm_state_t;
endpackage

// File: rtl/dram_fpm_timer.sv
// Module: down counter used for every timed phase.
// Loading value V makes 'expired' rise after exactly max(V,1) cycles.
// Assumes load has priority over counting.
module dram_fpm_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // count register: reload on demand, else count down to one and hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(1);
        else if (load)
            cnt <= (val == '0) ? W'(1) : val;
        else if (cnt > W'(1))
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == W'(1));
endmodule

// File: rtl/dram_fpm_rowreg.sv
// Module: open-row register with hit compare.
// Assumes set and clr are never high in the same cycle; clr wins if they are.
module dram_fpm_rowreg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set,
    input  logic         clr,
    input  logic [W-1:0] row_set,
    input  logic [W-1:0] row_query,
    output logic         hit
);
    logic         open_q;
    logic [W-1:0] row_q;

    // track which row is held open in the DRAM sense amplifiers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (clr) begin
            open_q <= 1'b0;
        end else if (set) begin
            open_q <= 1'b1;
            row_q  <= row_set;
        end
    end

    assign hit = open_q && (row_q == row_query);
endmodule

// File: rtl/dram_fpm_dqdrv.sv
// Module: tri-state driver for the DRAM data bus.
// Assumes the enable is low whenever the DRAM may drive the bus.
module dram_fpm_dqdrv #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] d,
    inout  wire  [W-1:0] pad
);
    // drive the bus only during a write
    assign pad = en ? d : {W{1'bz}};
endmodule

// File: rtl/page_dram_ctrl.sv
// Module: fast page mode controller for an asynchronous multiplexed-address DRAM.
// Holds the row open across same-row requests and pulses only CAS for them.
// Assumes all cfg_* inputs change only while req_ready is high; the DRAM
// timing itself is expressed entirely as cycle counts.
module page_dram_ctrl #(
    parameter int PIN_W  = 9,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_precharge,
    input  logic [CNT_W-1:0]     cfg_ras_cas,
    input  logic [CNT_W-1:0]     cfg_cas_width,
    input  logic [CNT_W-1:0]     cfg_access,
    input  logic [CNT_W-1:0]     cfg_idle,
    input  logic                 cfg_late_oe,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [2*PIN_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [PIN_W-1:0]     dram_addr,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic                 dram_oe_n,
    inout  wire  [DATA_W-1:0]    dram_dq
);
    import dram_fpm_pkg::*;

    localparam int ADDR_W = 2 * PIN_W;
    localparam int TW     = CNT_W + 1;

    fpm_state_t          st, nxt;
    logic                q_wr;
    logic [ADDR_W-1:0]   q_addr;
    logic [DATA_W-1:0]   q_wdata;
    logic                first_cas;
    logic                accept, hit, t_exp, t_load;
    logic [TW-1:0]       t_val;
    logic [PIN_W-1:0]    q_row, q_col;
    logic                row_set, row_clr, dq_en;

    assign q_row  = q_addr[ADDR_W-1:PIN_W];
    assign q_col  = q_addr[PIN_W-1:0];
    assign req_ready = (st == ST_IDLE) || (st == ST_OPEN);
    assign accept = req_valid && req_ready;

    dram_fpm_timer #(.W(TW)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .expired(t_exp)
    );

    dram_fpm_rowreg #(.W(PIN_W)) rowreg_i (
        .clk(clk), .rst_n(rst_n), .set(row_set), .clr(row_clr),
        .row_set(q_row), .row_query(req_addr[ADDR_W-1:PIN_W]), .hit(hit)
    );

    dram_fpm_dqdrv #(.W(DATA_W)) dqdrv_i (
        .en(dq_en), .d(q_wdata), .pad(dram_dq)
    );

    // next-state and timer reload selection
    always_comb begin
        nxt    = st;
        t_load = 1'b0;
        t_val  = TW'(1);
        unique case (st)
            ST_IDLE: if (accept) begin
                nxt = ST_PRE; t_load = 1'b1; t_val = TW'(1);
            end
            ST_OPEN: if (accept) begin
                t_load = 1'b1;
                if (hit) begin
                    nxt = ST_COL; t_val = TW'(1);
                end else begin
                    nxt = ST_PRE; t_val = {1'b0, cfg_precharge};
                end
            end else if (t_exp) begin
                nxt = ST_CLOSE; t_load = 1'b1; t_val = {1'b0, cfg_precharge};
            end
            ST_PRE: if (t_exp) begin
                nxt = ST_RCD; t_load = 1'b1; t_val = {1'b0, cfg_ras_cas};
            end
            ST_RCD: if (t_exp) begin
                nxt = ST_COL; t_load = 1'b1; t_val = TW'(1);
            end
            ST_COL: begin
                nxt = ST_CAS; t_load = 1'b1;
                t_val = q_wr ? {1'b0, cfg_cas_width}
                             : ({1'b0, cfg_access} + TW'(cfg_late_oe));
            end
            ST_CAS: if (t_exp) begin
                nxt = ST_CASHI; t_load = 1'b1; t_val = TW'(1);
            end
            ST_CASHI: begin
                nxt = ST_OPEN; t_load = 1'b1; t_val = {1'b0, cfg_idle};
            end
            ST_CLOSE: if (t_exp) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign row_set = (st == ST_PRE) && t_exp;
    assign row_clr = (nxt == ST_PRE) || (nxt == ST_CLOSE);

    // state, request capture and first-CAS-cycle flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            q_wr      <= 1'b0;
            q_addr    <= '0;
            q_wdata   <= '0;
            first_cas <= 1'b0;
        end else begin
            st        <= nxt;
            first_cas <= (st == ST_COL);
            if (accept) begin
                q_wr    <= req_write;
                q_addr  <= req_addr;
                q_wdata <= req_wdata;
            end
        end
    end

    // read data capture at the end of the access window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (st == ST_CAS) && t_exp && !q_wr;
            if ((st == ST_CAS) && t_exp && !q_wr)
                rd_data <= dram_dq;
        end
    end

    // DRAM pin decode from the state
    always_comb begin
        dram_ras_n = !((st == ST_RCD) || (st == ST_COL) || (st == ST_CAS) ||
                       (st == ST_CASHI) || (st == ST_OPEN));
        dram_cas_n = !(st == ST_CAS);
        dram_addr  = ((st == ST_PRE) || (st == ST_RCD)) ? q_row : q_col;
        dram_we_n  = !(q_wr && ((st == ST_COL) || (st == ST_CAS)));
        dram_oe_n  = !(!q_wr && (((st == ST_COL) && !cfg_late_oe) ||
                                 ((st == ST_CAS) && (!cfg_late_oe || !first_cas))));
        dq_en      = q_wr && ((st == ST_COL) || (st == ST_CAS));
    end
endmodule

// File: rtl/page_dram_ctrl_chk.sv
// Module: protocol checker bound to page_dram_ctrl.
// Observes only ports; assumes synchronous active-low reset.
module page_dram_ctrl_chk #(
    parameter int PIN_W  = 9,
    parameter int DATA_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_late_oe,
    input logic             req_ready,
    input logic             rd_valid,
    input logic [PIN_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n
);
    // R2: CAS only inside an asserted RAS
    p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    // R2: row address stable across the RAS fall
    p_row_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_addr));
    // R2: column address stable across the CAS fall
    p_col_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_addr));
    // R6: early mode has output enable low at the CAS fall
    p_early_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && dram_we_n && !cfg_late_oe) |-> !dram_oe_n);
    // R6: late mode keeps output enable high at the CAS fall, low one cycle later
    p_late_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && dram_we_n && cfg_late_oe) |-> dram_oe_n);
    p_late_oe_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && dram_we_n && cfg_late_oe) |=> !dram_oe_n);
    // R7: read valid is a single-cycle pulse
    p_rdv_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R8: write enable and output enable never overlap
    p_we_oe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_we_n && !dram_oe_n));
    // R8: write enable already low in the cycle before the CAS fall
    p_we_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));
    // R10: ready is never offered with an access in flight
    p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_cas_n && dram_we_n));
endmodule

bind page_dram_ctrl page_dram_ctrl_chk #(.PIN_W(PIN_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/page_dram_ctrl_tb_top.sv
// Bench: self-checking test of page_dram_ctrl against a behavioural DRAM.
module page_dram_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_precharge = 8'd3, cfg_ras_cas = 8'd2, cfg_cas_width = 8'd2;
    logic [7:0]  cfg_access = 8'd3, cfg_idle = 8'd200;
    logic        cfg_late_oe = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [8:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    wire  [7:0]  dram_dq;

    int checks = 0, errors = 0, cycles = 0;

    always #2 clk = ~clk;  // 250 MHz

    page_dram_ctrl dut_i (.*);

    // behavioural DRAM: row latched on RAS fall, column on CAS fall
    bit   [7:0] mem [bit [17:0]];
    logic [8:0] m_row;
    logic [7:0] m_data = '0;
    always @(negedge dram_ras_n) m_row = dram_addr;
    always @(negedge dram_cas_n) begin
        if (!dram_we_n) mem[{m_row, dram_addr}] = dram_dq;
        else m_data = mem.exists({m_row, dram_addr}) ? mem[{m_row, dram_addr}] : 8'h00;
    end
    assign dram_dq = (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n) ? m_data : 8'bz;

    // pin monitor sampled at the falling clock edge
    int   ras_falls = 0, cas_w = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, oe_at_fall = 1'b1, we_at_fall = 1'b1;
    logic [7:0] dq_at_fall = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!dram_ras_n && prev_ras) ras_falls++;
            if (!dram_cas_n) begin
                if (prev_cas) begin
                    cas_w = 1; oe_at_fall = dram_oe_n;
                    we_at_fall = dram_we_n; dq_at_fall = dram_dq;
                end else cas_w++;
            end
        end
        prev_ras = dram_ras_n;
        prev_cas = dram_cas_n;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_op(input bit wr, input logic [17:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        lat = 0; rd = '0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 ready low after accept", int'(req_ready), 0);
        if (!wr) begin
            while (!rd_valid && lat < 500) begin
                lat++;
                @(negedge clk);
            end
            rd = rd_data;
        end
        while (!req_ready) @(negedge clk);
    endtask

    // vectors: {write, row[8:0], col[8:0], data[7:0]}
    localparam logic [26:0] VEC [11] = '{
        {1'b1, 9'd5,   9'd3,   8'hA5},
        {1'b1, 9'd5,   9'd4,   8'h3C},
        {1'b0, 9'd5,   9'd3,   8'h00},
        {1'b0, 9'd5,   9'd4,   8'h00},
        {1'b1, 9'd9,   9'd3,   8'h77},
        {1'b0, 9'd9,   9'd3,   8'h00},
        {1'b0, 9'd5,   9'd3,   8'h00},
        {1'b1, 9'd511, 9'd511, 8'hFF},
        {1'b0, 9'd511, 9'd511, 8'h00},
        {1'b0, 9'd9,   9'd3,   8'h00},
        {1'b0, 9'd0,   9'd0,   8'h00}
    };

    bit   [7:0] shadow [bit [17:0]];
    bit         b_open = 1'b0;
    logic [8:0] b_row = '0;

    // expected read latency from the bench's own open-row model
    function automatic int exp_lat(input logic [8:0] row);
        int a, p, d;
        a = int'(cfg_access) + int'(cfg_late_oe);
        p = (cfg_precharge == 0) ? 1 : int'(cfg_precharge);
        d = (cfg_ras_cas == 0) ? 1 : int'(cfg_ras_cas);
        if (!b_open) return 2 + d + a;
        if (b_row == row) return 1 + a;
        return p + 1 + d + a;
    endfunction

    task automatic run_op(input bit wr, input logic [8:0] row, input logic [8:0] col,
                          input logic [7:0] d, input string tag);
        logic [7:0] rd;
        int lat, el, f0;
        bit ehit;
        logic [7:0] ed;
        ehit = b_open && (b_row == row);
        el = exp_lat(row);
        ed = shadow.exists({row, col}) ? shadow[{row, col}] : 8'h00;
        f0 = ras_falls;
        do_op(wr, {row, col}, d, rd, lat);
        chk(ehit ? "R3 no RAS fall on hit" : "R4 one RAS fall on miss",
            ras_falls - f0, ehit ? 0 : 1);
        if (wr) begin
            shadow[{row, col}] = d;
            chk("R8 write CAS width", cas_w, int'(cfg_cas_width));
            chk("R8 WE low at CAS fall", int'(we_at_fall), 0);
            chk("R8 data on bus at CAS fall", int'(dq_at_fall), int'(d));
        end else begin
            chk({tag, " read data R7"}, int'(rd), int'(ed));
            chk({tag, " read latency R3/R4/R5"}, lat, el);
            chk("R6 read CAS width", cas_w, int'(cfg_access) + int'(cfg_late_oe));
            chk("R6 OE level at CAS fall", int'(oe_at_fall), int'(cfg_late_oe));
        end
        b_open = 1'b1;
        b_row  = row;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ras_n", int'(dram_ras_n), 1);
        chk("R1 cas_n", int'(dram_cas_n), 1);
        chk("R1 we_n/oe_n", int'({dram_we_n, dram_oe_n}), 3);
        chk("R1 rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 dq undriven", int'(dram_dq === 8'bz), 1);

        // table walk: hits, misses, first access from idle (R2..R8)
        foreach (VEC[i])
            run_op(VEC[i][26], VEC[i][25:17], VEC[i][16:8], VEC[i][7:0], "vec");

        // R6: late output enable, miss then hit
        cfg_late_oe = 1'b1;
        run_op(1'b0, 9'd5, 9'd3, 8'h00, "late R6");
        run_op(1'b0, 9'd5, 9'd4, 8'h00, "late R6 hit");

        // R4: zero precharge count acts as one cycle
        cfg_late_oe = 1'b0;
        cfg_precharge = 8'd0;
        run_op(1'b0, 9'd9, 9'd3, 8'h00, "zero precharge R4");
        cfg_precharge = 8'd3;

        // R9: idle timeout closes the row
        cfg_idle = 8'd20;
        run_op(1'b0, 9'd9, 9'd3, 8'h00, "pre-timeout");
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 19) chk("R9 RAS still low before timeout", int'(dram_ras_n), 0);
            if (k == 20) chk("R9 RAS high at timeout", int'(dram_ras_n), 1);
        end
        repeat (10) @(negedge clk);
        b_open = 1'b0;
        run_op(1'b0, 9'd9, 9'd3, 8'h00, "after timeout R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule